// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block collects the interrupt sources of a two-channel serial module into one 8-bit status word and one active-high interrupt request. It keeps a transmitter-ready flag for each channel. This flag is driven by the transmitter enable, by the CPU loading the holding register, and by the serializer moving a character into its shift register. Delta-break and change-of-state events are held until they are cleared. Receiver-ready and crystal-ready are sampled levels.

An 8-bit enable register chooses which status bits can drive the request. Software can write this register only while the module-stop input is low. The enable register never hides a bit from the status output. The crystal-ready bit is never routed to the request.

Top module: `ser_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `status_o` is 8'h00 and `irq_o` is 0. The enable register also resets to all zeros.
- R2: `irq_o` is registered. It is 1 exactly one clock after a cycle in which some status bit and its matching enable bit are both 1, and it is 0 otherwise.
- R3: A status bit whose enable bit is 0 has no effect on `irq_o`, but it still appears on `status_o`.
- R4: Status bit 3 (crystal ready) never raises `irq_o`. Bit 3 of a write to the enable register is ignored.
- R5: A write to the enable register (`ier_we_i` high) is discarded while `stop_i` is 1. When `stop_i` is 0, it takes effect at that clock edge.
- R6: A channel's transmitter-ready bit becomes 1 one clock after its `tx_en_i` rises.
- R7: While the channel is enabled, a `tx_xfer_i` strobe sets transmitter-ready at the next clock.
- R8: A `tx_load_i` strobe clears transmitter-ready at the next clock. When load and transfer come in the same cycle, the load wins.
- R9: While `tx_en_i` is 0, transmitter-ready is 0, and load and transfer strobes are ignored. A character loaded while disabled is dropped, so transmitter-ready reads 1 after re-enable.
- R10: Delta-break and change-of-state bits set on their set strobe and hold until their clear strobe arrives. A set strobe wins over a clear strobe in the same cycle.
- R11: Receiver-ready and crystal-ready status bits follow their inputs one clock later.
- R12: The status and enable bit layout is: 7 change-of-state, 6 delta-break B, 5 rx-ready B, 4 tx-ready B, 3 crystal-ready (status only), 2 delta-break A, 1 rx-ready A, 0 tx-ready A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_rdy_i | input | 2 | Receiver-ready level per channel (bit 0 = A) |
| dbrk_set_i | input | 2 | Delta-break event strobe per channel |
| dbrk_clr_i | input | 2 | Delta-break clear strobe per channel |
| cos_set_i | input | 1 | Change-of-state event strobe |
| cos_clr_i | input | 1 | Change-of-state clear strobe |
| xtal_rdy_i | input | 1 | Crystal-ready level |
| tx_en_i | input | 2 | Transmitter enable per channel |
| tx_load_i | input | 2 | CPU loaded the holding register |
| tx_xfer_i | input | 2 | Holding register moved to the shift register |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| stop_i | input | 1 | Module stop; locks the enable register |
| status_o | output | 8 | Raw status word |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every status bit is registered, so a wrong bit shows on `status_o` one clock after the input that should have set it. The interrupt request lags the status by one more clock. An enable register that silently took a write while stopped, or that kept bit 3, stays hidden until a status bit in that position is raised. For this reason the tests raise sources after each enable-register operation, so that the wrong mask shows on `irq_o` within two clocks. A transmitter-ready flag with the wrong priority shows only in the cycle of a simultaneous load and transfer, or at an enable edge, so those cycles are driven on purpose.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int unsigned NCH  = 2;
  localparam int unsigned SW   = 8;
  localparam int unsigned B_TXA = 0;
  localparam int unsigned B_RXA = 1;
  localparam int unsigned B_DBA = 2;
  localparam int unsigned B_XTL = 3;
  localparam int unsigned B_TXB = 4;
  localparam int unsigned B_RXB = 5;
  localparam int unsigned B_DBB = 6;
  localparam int unsigned B_COS = 7;
  localparam logic [SW-1:0] IER_WMASK = ~(SW'(1) << B_XTL);
endpackage

// File: rtl/ser_irq_txrdy.sv
module ser_irq_txrdy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic xfer_i,
  output logic rdy_o
);
  logic en_q, rdy_q, rdy_d;

  always_comb begin
    if (!en_i)       rdy_d = 1'b0;
    else if (!en_q)  rdy_d = 1'b1;  // first enable: holding reg treated empty
    else if (load_i) rdy_d = 1'b0;
    else if (xfer_i) rdy_d = 1'b1;
    else             rdy_d = rdy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      rdy_q <= rdy_d;
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/ser_irq_sticky.sv
module ser_irq_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_q[i] <= 1'b0;
      else if (set_i[i]) q_q[i] <= 1'b1;  // set wins
      else if (clr_i[i]) q_q[i] <= 1'b0;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/ser_irq_mask.sv
module ser_irq_mask
  import ser_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] wdata_i,
  input  logic          stop_i,
  input  logic [SW-1:0] status_i,
  output logic [SW-1:0] ier_o,
  output logic          irq_o
);
  logic [SW-1:0] ier_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (we_i && !stop_i) ier_q <= wdata_i & IER_WMASK;
      irq_q <= |(status_i & ier_q & IER_WMASK);
    end
  end

  assign ier_o = ier_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl
  import ser_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rx_rdy_i,
  input  logic [1:0] dbrk_set_i,
  input  logic [1:0] dbrk_clr_i,
  input  logic       cos_set_i,
  input  logic       cos_clr_i,
  input  logic       xtal_rdy_i,
  input  logic [1:0] tx_en_i,
  input  logic [1:0] tx_load_i,
  input  logic [1:0] tx_xfer_i,
  input  logic       ier_we_i,
  input  logic [7:0] ier_wdata_i,
  input  logic       stop_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [NCH-1:0] tx_rdy;
  logic [NCH-1:0] rx_q;
  logic           xtal_q;
  logic [NCH:0]   evt_q;   // {cos, dbrk B, dbrk A}
  logic [SW-1:0]  status;
  logic [SW-1:0]  ier_q;

  for (genvar c = 0; c < NCH; c++) begin : g_tx
    ser_irq_txrdy u_txrdy (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (tx_en_i[c]),
      .load_i (tx_load_i[c]),
      .xfer_i (tx_xfer_i[c]),
      .rdy_o  (tx_rdy[c])
    );
  end

  ser_irq_sticky #(.N(NCH+1)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({cos_set_i, dbrk_set_i}),
    .clr_i  ({cos_clr_i, dbrk_clr_i}),
    .q_o    (evt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      xtal_q <= 1'b0;
    end else begin
      rx_q   <= rx_rdy_i;
      xtal_q <= xtal_rdy_i;
    end
  end

  always_comb begin
    status        = '0;
    status[B_TXA] = tx_rdy[0];
    status[B_RXA] = rx_q[0];
    status[B_DBA] = evt_q[0];
    status[B_XTL] = xtal_q;
    status[B_TXB] = tx_rdy[1];
    status[B_RXB] = rx_q[1];
    status[B_DBB] = evt_q[1];
    status[B_COS] = evt_q[2];
  end

  ser_irq_mask u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ier_we_i),
    .wdata_i  (ier_wdata_i),
    .stop_i   (stop_i),
    .status_i (status),
    .ier_o    (ier_q),
    .irq_o    (irq_o)
  );

  assign status_o = status;
endmodule

// File: rtl/ser_irq_ctrl_chk.sv
module ser_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] status_i,
  input logic       irq_i,
  input logic [7:0] ier_i,
  input logic       stop_i,
  input logic       we_i,
  input logic [1:0] tx_en_i,
  input logic [1:0] rx_rdy_i,
  input logic [1:0] dbrk_set_i
);
  AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == |($past(status_i) & $past(ier_i) & 8'hF7));  // R2
  AST_XTAL_NEVER_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_i[3] == 1'b0);  // R4
  AST_IER_LOCKED_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) && $past(we_i) |-> ier_i == $past(ier_i));  // R5
  AST_TXA_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_en_i[0]) |-> !status_i[0]);  // R9
  AST_TXB_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_en_i[1]) |-> !status_i[4]);  // R9
  AST_DBRK_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dbrk_set_i[0]) |-> status_i[2]);  // R10
  AST_RX_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[1] == $past(rx_rdy_i[0]) && status_i[5] == $past(rx_rdy_i[1]));  // R11
endmodule

bind ser_irq_ctrl ser_irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_o),
  .irq_i      (irq_o),
  .ier_i      (ier_q),
  .stop_i     (stop_i),
  .we_i       (ier_we_i),
  .tx_en_i    (tx_en_i),
  .rx_rdy_i   (rx_rdy_i),
  .dbrk_set_i (dbrk_set_i)
);

// File: tb/ser_irq_ctrl_tb_top.sv
module ser_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx_rdy = '0, dbrk_set = '0, dbrk_clr = '0;
  logic       cos_set = 1'b0, cos_clr = 1'b0, xtal = 1'b0;
  logic [1:0] tx_en = '0, tx_load = '0, tx_xfer = '0;
  logic       we = 1'b0, stop = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] status;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_st_q[$];
  logic       exp_irq_q[$];
  string      tag_q[$];

  // reference model state
  logic [7:0] m_st = '0, m_ier = '0;
  logic [1:0] m_en_prev = '0;

  always #2 clk = ~clk;  // 250 MHz

  ser_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_rdy_i(rx_rdy), .dbrk_set_i(dbrk_set),
    .dbrk_clr_i(dbrk_clr), .cos_set_i(cos_set), .cos_clr_i(cos_clr),
    .xtal_rdy_i(xtal), .tx_en_i(tx_en), .tx_load_i(tx_load), .tx_xfer_i(tx_xfer),
    .ier_we_i(we), .ier_wdata_i(wdata), .stop_i(stop),
    .status_o(status), .irq_o(irq)
  );

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got status=%h irq=%b, expected status=%h irq=%b",
               tag, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  // driver: model one clock from the current inputs, push expectation, clock, clear strobes
  task automatic cyc(string tag);
    logic [7:0] ns;
    logic       nirq;
    logic [1:0] txb;
    for (int c = 0; c < 2; c++) begin
      logic cur;
      logic t;
      cur = (c == 0) ? m_st[0] : m_st[4];
      if (!tx_en[c])          t = 1'b0;
      else if (!m_en_prev[c]) t = 1'b1;
      else if (tx_load[c])    t = 1'b0;
      else if (tx_xfer[c])    t = 1'b1;
      else                    t = cur;
      txb[c] = t;
    end
    ns[0] = txb[0];
    ns[4] = txb[1];
    ns[1] = rx_rdy[0];
    ns[5] = rx_rdy[1];
    ns[3] = xtal;
    ns[2] = dbrk_set[0] | (m_st[2] & ~dbrk_clr[0]);
    ns[6] = dbrk_set[1] | (m_st[6] & ~dbrk_clr[1]);
    ns[7] = cos_set | (m_st[7] & ~cos_clr);
    nirq = |(m_st & m_ier & 8'hF7);
    if (we && !stop) m_ier = wdata & 8'hF7;
    m_st = ns;
    m_en_prev = tx_en;
    exp_st_q.push_back(ns);
    exp_irq_q.push_back(nirq);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    dbrk_set = '0; dbrk_clr = '0; cos_set = 1'b0; cos_clr = 1'b0;
    tx_load = '0; tx_xfer = '0; we = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_st_q.size() > 0) begin
        logic [7:0] es;
        logic       ei;
        string      tg;
        es = exp_st_q.pop_front();
        ei = exp_irq_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {status, irq}, {es, ei});
      end
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {status, irq}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1 after reset");

    tx_en = 2'b01; cyc("R6 enable A");
    cyc("R6 A holds");
    tx_en = 2'b11; cyc("R6 enable B");
    tx_load[0] = 1'b1; cyc("R8 load A clears");
    tx_xfer[0] = 1'b1; cyc("R7 xfer A sets");
    tx_load[0] = 1'b1; tx_xfer[0] = 1'b1; cyc("R8 load beats xfer");
    we = 1'b1; wdata = 8'hFF; cyc("R2 write enables");
    cyc("R2 irq from tx B");
    tx_load[1] = 1'b1; cyc("R2 load B");
    cyc("R2 irq drops");
    xtal = 1'b1; cyc("R4 xtal raised");
    cyc("R4 xtal no irq");
    cyc("R4 xtal still no irq");
    stop = 1'b1; we = 1'b1; wdata = 8'h00; cyc("R5 write while stopped");
    tx_xfer[0] = 1'b1; cyc("R5 xfer A");
    cyc("R5 irq proves mask kept");
    stop = 1'b0; we = 1'b1; wdata = 8'h02; cyc("R5 write accepted");
    dbrk_set[0] = 1'b1; cyc("R3 dbrk A masked");
    cyc("R3 masked bit readable no irq");
    rx_rdy[0] = 1'b1; cyc("R11 rx A level");
    cyc("R2 irq from rx A");
    rx_rdy = 2'b10; cyc("R11 rx B level");
    dbrk_set[0] = 1'b1; dbrk_clr[0] = 1'b1; cyc("R10 set beats clear");
    dbrk_clr[0] = 1'b1; cyc("R10 clear A");
    dbrk_set[1] = 1'b1; cos_set = 1'b1; cyc("R12 bits 6 and 7");
    cyc("R10 sticky hold");
    cos_clr = 1'b1; cyc("R10 clear cos");
    we = 1'b1; wdata = 8'h80; cos_set = 1'b1; cyc("R12 cos enable");
    cyc("R12 cos irq");
    tx_en[1] = 1'b0; tx_xfer[1] = 1'b1; cyc("R9 disable B");
    tx_load[1] = 1'b1; cyc("R9 load while off");
    tx_xfer[1] = 1'b1; cyc("R9 xfer while off");
    tx_en[1] = 1'b1; cyc("R9 re-enable ready");
    xtal = 1'b0; rx_rdy = '0; cyc("R11 levels drop");
    cyc("final");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule